// File: doc/BRIEF.md
# BCD Calendar Clock with Hundredths

This block is the counting core of a real-time clock. A 100 Hz tick advances a chain of packed-BCD counters. The chain runs from hundredths of a second through seconds, minutes and hours, then on to day of week, date, month and a two-digit year. Hours follow either a 24-hour or a 12-hour convention. The 12-hour convention carries a PM flag. The date rolls over at the true end of each month. February gets a 29th day whenever the year value is a multiple of four.

The running counters are private working state. Software reads a separate snapshot bank. Every field of that bank is refreshed from the counters in one shared clock edge. A hold input freezes the snapshot, so that a sequence of reads spans a single instant. A write places the new byte in the snapshot at once. The working counter adopts that byte at the next tick, in place of its normal increment.

Top module: `rtc_bcd_chain`

## Requirements
- R1: After reset the snapshot reads hundredths 00, seconds 00, minutes 00, hours 00 (24-hour mode), day of week 01, date 01, month 01 and year 00.
- R2: Each tick adds one to the hundredths count in BCD. At 99 the count goes to 00 and carries into seconds. Without a tick no count changes.
- R3: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R4: The hours byte has bit 6 as the mode bit, where 0 selects 24-hour mode. In 24-hour mode bits 5:0 hold BCD hours 00 to 23, and 23 rolls to 00 while advancing the day.
- R5: With bit 6 set, bits 4:0 hold BCD hours 01 to 12 and bit 5 is the PM flag. The sequence runs 12, 01 … 11. The PM flag flips on each 11-to-12 step. The step from 11 PM to 12 AM advances the day.
- R6: Day of week counts 01 to 07 and returns to 01 at each day rollover.
- R7: The date rolls to 01 after day 31. For April, June, September and November it rolls after day 30. For February it rolls after day 28, or after day 29 when the BCD year value is divisible by four (year 00 included).
- R8: Month 12 rolls to 01 and advances the year. Year 99 rolls to 00.
- R9: Register indices are: 0 hundredths, 1 seconds, 2 minutes, 4 hours, 6 day of week, 8 date, 9 month, 0xA year. Every other index reads 0x00, and writes to it change no readable byte.
- R10: A tick registered at clock edge N updates the counters at N. All snapshot bytes take the new values together at edge N+1.
- R11: While hold is 1 the snapshot does not change, but the counters keep counting. The first edge with hold at 0 copies the current counters into the snapshot.
- R12: A written byte is readable from the next edge. At the following tick the matching counter loads that byte instead of incrementing, while the other fields step normally. No copy from the counters overwrites a write that is still waiting for that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at 100 Hz that advances the chain |
| hold | input | 1 | Freezes the snapshot bank while 1 |
| wr_en | input | 1 | Write strobe for the snapshot bank |
| wr_idx | input | IDX_W | Register index of the write |
| wr_data | input | 8 | Byte to write |
| rd_idx | input | IDX_W | Register index to read |
| rd_data | output | 8 | Snapshot byte at rd_idx, combinational |

## Verification
A tick sampled at edge N reaches the counters at that edge. It reaches the readable snapshot one edge later. The bench therefore waits two falling edges after raising tick before it reads, and it also reads in the gap between the two edges to confirm the old value is still shown. A write is visible one edge after the strobe. A released hold shows up one edge after the release. The read port is combinational, so the bench sets rd_idx on a falling edge and samples a moment later, well before the next rising edge.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_TIME   = 4;
  localparam int N_CAL    = 4;
  localparam int N_FIELDS = N_TIME + N_CAL;

  typedef logic [BYTE_W-1:0] byte_t;

  // Add one to a two-digit packed BCD value (no range check).
  function automatic byte_t bcd_inc(input byte_t v);
    byte_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Increment, returning to 'bottom' once 'top' has been reached.
  function automatic byte_t bcd_step_wrap(input byte_t v, input byte_t top,
                                          input byte_t bottom);
    return (v >= top) ? bottom : bcd_inc(v);
  endfunction

  function automatic logic [6:0] bcd_to_bin(input byte_t v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic year_is_leap(input byte_t yr);
    logic [6:0] b;
    b = bcd_to_bin(yr);
    return b[1:0] == 2'b00;
  endfunction

  // Last valid date of a month, in BCD.
  function automatic byte_t month_last_day(input byte_t mon, input byte_t yr);
    byte_t r;
    case (mon)
      8'h02:                      r = year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

  // Hours byte: bit6 = 12-hour mode, bit5 = PM (12-hour only).
  function automatic byte_t hour_next(input byte_t h);
    byte_t r;
    byte_t lo;
    if (h[6]) begin
      lo = {3'b000, h[4:0]};
      lo = (lo >= 8'h12) ? 8'h01 : bcd_inc(lo);
      r  = {1'b0, 1'b1, h[5] ^ (h[4:0] == 5'h11), lo[4:0]};
    end else begin
      lo = {2'b00, h[5:0]};
      r  = (lo >= 8'h23) ? 8'h00 : bcd_inc(lo);
    end
    return r;
  endfunction

  function automatic logic hour_ends_day(input byte_t h);
    return h[6] ? (h[5] && (h[4:0] == 5'h11)) : (h[5:0] >= 6'h23);
  endfunction

  // Register index of each field; order of fields is the carry order.
  function automatic logic [3:0] field_index(input int f);
    logic [3:0] r;
    case (f)
      0:       r = 4'h0;
      1:       r = 4'h1;
      2:       r = 4'h2;
      3:       r = 4'h4;
      4:       r = 4'h6;
      5:       r = 4'h8;
      6:       r = 4'h9;
      default: r = 4'hA;
    endcase
    return r;
  endfunction

  // Day of week, date and month start at 01; everything else at 00.
  function automatic byte_t field_reset(input int f);
    return (f >= 4 && f <= 6) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/rtc_clock_core.sv
module rtc_clock_core
  import rtc_bcd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [N_TIME-1:0]             ld_mask,
  input  logic [N_TIME-1:0][BYTE_W-1:0] ld_val,
  output logic [N_TIME-1:0][BYTE_W-1:0] cnt,
  output logic                          day_step
);
  // field order: 0 hundredths, 1 seconds, 2 minutes, 3 hours
  logic [N_TIME-1:0]             at_top;
  logic [N_TIME-1:0]             step;
  logic [N_TIME-1:0][BYTE_W-1:0] nxt;

  always_comb begin
    at_top[0] = cnt[0] >= 8'h99;
    at_top[1] = cnt[1] >= 8'h59;
    at_top[2] = cnt[2] >= 8'h59;
    at_top[3] = hour_ends_day(cnt[3]);
    nxt[0]    = bcd_step_wrap(cnt[0], 8'h99, 8'h00);
    nxt[1]    = bcd_step_wrap(cnt[1], 8'h59, 8'h00);
    nxt[2]    = bcd_step_wrap(cnt[2], 8'h59, 8'h00);
    nxt[3]    = hour_next(cnt[3]);
    step[0]   = tick;
    for (int i = 1; i < N_TIME; i++) step[i] = step[i-1] & at_top[i-1];
  end

  assign day_step = step[N_TIME-1] & at_top[N_TIME-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_TIME; i++) cnt[i] <= field_reset(i);
    end else begin
      for (int i = 0; i < N_TIME; i++) begin
        if (tick && ld_mask[i]) cnt[i] <= ld_val[i];
        else if (step[i])       cnt[i] <= nxt[i];
      end
    end
  end

  AST_TIME_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R2
  AST_PM_FLIPS_AT_TWELVE: assert property (@(posedge clk) disable iff (!rst_n)
    (step[3] && !ld_mask[3] && cnt[3][6] && cnt[3][4:0] == 5'h11)
    |=> cnt[3][5] != $past(cnt[3][5])); // R5
  AST_SECONDS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (step[1] && !ld_mask[1]) |=> cnt[1] <= 8'h59); // R3
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_bcd_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         day_step,
  input  logic [N_CAL-1:0]             ld_mask,
  input  logic [N_CAL-1:0][BYTE_W-1:0] ld_val,
  output logic [N_CAL-1:0][BYTE_W-1:0] cal
);
  // field order: 0 day of week, 1 date, 2 month, 3 year
  logic [N_CAL-1:0]             at_top;
  logic [N_CAL-1:0]             step;
  logic [N_CAL-1:0][BYTE_W-1:0] nxt;
  byte_t                        last_day;

  always_comb begin
    last_day  = month_last_day(cal[2], cal[3]);
    at_top[0] = cal[0] >= 8'h07;
    at_top[1] = cal[1] >= last_day;
    at_top[2] = cal[2] >= 8'h12;
    at_top[3] = cal[3] >= 8'h99;
    nxt[0]    = bcd_step_wrap(cal[0], 8'h07, 8'h01);
    nxt[1]    = bcd_step_wrap(cal[1], last_day, 8'h01);
    nxt[2]    = bcd_step_wrap(cal[2], 8'h12, 8'h01);
    nxt[3]    = bcd_step_wrap(cal[3], 8'h99, 8'h00);
    step[0]   = day_step;
    step[1]   = day_step;
    step[2]   = day_step & at_top[1];
    step[3]   = step[2] & at_top[2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CAL; i++) cal[i] <= field_reset(i + N_TIME);
    end else begin
      for (int i = 0; i < N_CAL; i++) begin
        if (tick && ld_mask[i]) cal[i] <= ld_val[i];
        else if (step[i])       cal[i] <= nxt[i];
      end
    end
  end

  AST_DATE_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !ld_mask[1]) |=> cal[1] != 8'h00); // R7
  AST_WEEKDAY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !ld_mask[0]) |=> (cal[0] >= 8'h01 && cal[0] <= 8'h07)); // R6
  AST_CAL_ONLY_ON_DAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!day_step && !(tick && ld_mask != '0)) |=> $stable(cal)); // R2
endmodule

// File: rtl/rtc_user_bank.sv
module rtc_user_bank
  import rtc_bcd_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick,
  input  logic                            hold,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [BYTE_W-1:0]               wr_data,
  input  logic [IDX_W-1:0]                rd_idx,
  output logic [BYTE_W-1:0]               rd_data,
  input  logic [N_FIELDS-1:0][BYTE_W-1:0] live,
  output logic [N_FIELDS-1:0][BYTE_W-1:0] shadow,
  output logic [N_FIELDS-1:0]             pend
);
  logic [N_FIELDS-1:0] wr_hit;
  logic                xfer_due;
  logic                xfer_fire;

  always_comb begin
    for (int f = 0; f < N_FIELDS; f++)
      wr_hit[f] = wr_en && (wr_idx == IDX_W'(field_index(f)));
  end

  assign xfer_fire = xfer_due && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) xfer_due <= 1'b0;
    else if (tick) xfer_due <= 1'b1;
    else if (!hold) xfer_due <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < N_FIELDS; f++) begin
        shadow[f] <= field_reset(f);
        pend[f]   <= 1'b0;
      end
    end else begin
      for (int f = 0; f < N_FIELDS; f++) begin
        if (wr_hit[f])                  shadow[f] <= wr_data;
        else if (xfer_fire && !pend[f]) shadow[f] <= live[f];
        if (wr_hit[f])                  pend[f] <= 1'b1;
        else if (tick)                  pend[f] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int f = 0; f < N_FIELDS; f++)
      if (rd_idx == IDX_W'(field_index(f))) rd_data = shadow[f];
  end

  AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> $stable(shadow)); // R11
  AST_SNAPSHOT_COPIES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && !wr_en && pend == '0) |=> shadow == $past(live)); // R10
  AST_PENDING_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> pend == '0); // R12
endmodule

// File: rtl/rtc_bcd_chain.sv
module rtc_bcd_chain
  import rtc_bcd_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data
);
  logic [N_TIME-1:0][BYTE_W-1:0]   time_cnt;
  logic [N_CAL-1:0][BYTE_W-1:0]    cal_cnt;
  logic [N_FIELDS-1:0][BYTE_W-1:0] live;
  logic [N_FIELDS-1:0][BYTE_W-1:0] shadow;
  logic [N_FIELDS-1:0]             pend;
  logic                            day_step;

  assign live = {cal_cnt, time_cnt};

  rtc_clock_core i_clock_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ld_mask  (pend[N_TIME-1:0]),
    .ld_val   (shadow[N_TIME-1:0]),
    .cnt      (time_cnt),
    .day_step (day_step)
  );

  rtc_calendar_core i_calendar_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .day_step (day_step),
    .ld_mask  (pend[N_FIELDS-1:N_TIME]),
    .ld_val   (shadow[N_FIELDS-1:N_TIME]),
    .cal      (cal_cnt)
  );

  rtc_user_bank #(.IDX_W(IDX_W)) i_user_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .hold    (hold),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .live    (live),
    .shadow  (shadow),
    .pend    (pend)
  );

  AST_DAY_NEEDS_TOP_OF_HOUR: assert property (@(posedge clk) disable iff (!rst_n)
    day_step |-> (time_cnt[0] == 8'h99 && time_cnt[1] == 8'h59 && time_cnt[2] == 8'h59)); // R4
endmodule

// File: tb/test_rtc_bcd_chain.sv
module test_rtc_bcd_chain;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       hold = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_idx = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;

  rtc_bcd_chain i_rtc_bcd_chain (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold(hold), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] to_bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] d);
    @(negedge clk);
    rd_idx = idx;
    #1 d = rd_data;
  endtask

  task automatic rd_chk(input string req, input string what,
                        input logic [3:0] idx, input logic [7:0] exp);
    logic [7:0] d;
    rd(idx, d);
    chk(req, what, d, exp);
  endtask

  // tick seen at edge N, snapshot at N+1, ends at the falling edge after N+1
  task automatic step_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] hs, sec, mn, hr, dw, dt, mo, yr);
    wr(4'h0, hs); wr(4'h1, sec); wr(4'h2, mn); wr(4'h4, hr);
    wr(4'h6, dw); wr(4'h8, dt); wr(4'h9, mo); wr(4'hA, yr);
    step_tick();
  endtask

  task automatic t_reset();
    rd_chk("R1", "hundredths", 4'h0, 8'h00);
    rd_chk("R1", "seconds", 4'h1, 8'h00);
    rd_chk("R1", "minutes", 4'h2, 8'h00);
    rd_chk("R1", "hours", 4'h4, 8'h00);
    rd_chk("R1", "weekday", 4'h6, 8'h01);
    rd_chk("R1", "date", 4'h8, 8'h01);
    rd_chk("R1", "month", 4'h9, 8'h01);
    rd_chk("R1", "year", 4'hA, 8'h00);
  endtask

  task automatic t_hundredths();
    logic [7:0] d;
    step_tick();
    rd_chk("R2", "hundredths after one tick", 4'h0, 8'h01);
    repeat (6) @(negedge clk);
    rd_chk("R2", "no change without tick", 4'h0, 8'h01);
    set_time(8'h09, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    step_tick();
    rd_chk("R2", "digit carry 09->10", 4'h0, 8'h10);
    set_time(8'h99, 8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    step_tick();
    rd_chk("R2", "99 wraps", 4'h0, 8'h00);
    rd(4'h1, d);
    chk("R3", "seconds carry 09->10", d, 8'h10);
  endtask

  task automatic t_latency();
    logic [7:0] d;
    set_time(8'h40, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    rd_idx = 4'h0;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    #1 d = rd_data;
    chk("R10", "snapshot still old one edge after tick", d, 8'h40);
    @(negedge clk);
    #1 d = rd_data;
    chk("R10", "snapshot new two edges after tick", d, 8'h41);
  endtask

  task automatic t_midnight();
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    step_tick();
    rd_chk("R2", "hundredths", 4'h0, 8'h00);
    rd_chk("R3", "seconds wrap", 4'h1, 8'h00);
    rd_chk("R3", "minutes wrap", 4'h2, 8'h00);
    rd_chk("R4", "hours 23->00", 4'h4, 8'h00);
    rd_chk("R6", "weekday 7->1", 4'h6, 8'h01);
    rd_chk("R7", "date 31->01", 4'h8, 8'h01);
    rd_chk("R8", "month 12->01", 4'h9, 8'h01);
    rd_chk("R8", "year 99->00", 4'hA, 8'h00);
    set_time(8'h99, 8'h59, 8'h59, 8'h19, 8'h03, 8'h05, 8'h03, 8'h10);
    step_tick();
    rd_chk("R4", "hours 19->20", 4'h4, 8'h20);
    rd_chk("R6", "weekday unchanged mid-day", 4'h6, 8'h03);
  endtask

  task automatic t_twelve_hour();
    set_time(8'h99, 8'h59, 8'h59, 8'h51, 8'h02, 8'h05, 8'h06, 8'h20);
    step_tick();
    rd_chk("R5", "11 AM -> 12 PM", 4'h4, 8'h72);
    rd_chk("R5", "date held at noon", 4'h8, 8'h05);
    step_tick();
    rd_chk("R5", "hours held mid-hour", 4'h4, 8'h72);
    set_time(8'h99, 8'h59, 8'h59, 8'h72, 8'h02, 8'h05, 8'h06, 8'h20);
    step_tick();
    rd_chk("R5", "12 PM -> 01 PM", 4'h4, 8'h61);
    set_time(8'h99, 8'h59, 8'h59, 8'h71, 8'h02, 8'h05, 8'h06, 8'h20);
    step_tick();
    rd_chk("R5", "11 PM -> 12 AM", 4'h4, 8'h52);
    rd_chk("R5", "day advances at midnight", 4'h8, 8'h06);
    rd_chk("R6", "weekday advances", 4'h6, 8'h03);
    set_time(8'h99, 8'h59, 8'h59, 8'h52, 8'h02, 8'h05, 8'h06, 8'h20);
    step_tick();
    rd_chk("R5", "12 AM -> 01 AM", 4'h4, 8'h41);
  endtask

  task automatic t_month_lengths();
    for (int y = 23; y <= 24; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int last;
        if (m == 2) last = (y % 4 == 0) ? 29 : 28;
        else if (m == 4 || m == 6 || m == 9 || m == 11) last = 30;
        else last = 31;
        set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, to_bcd(last), to_bcd(m), to_bcd(y));
        step_tick();
        rd_chk("R7", $sformatf("date after last day m%0d y%0d", m, y), 4'h8, 8'h01);
        rd_chk("R8", $sformatf("month after m%0d y%0d", m, y), 4'h9, to_bcd(m % 12 + 1));
      end
    end
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    step_tick();
    rd_chk("R7", "year 00 leap day", 4'h8, 8'h29);
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h01);
    step_tick();
    rd_chk("R7", "january 30->31", 4'h8, 8'h31);
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h45);
    step_tick();
    rd_chk("R8", "year 45->46", 4'hA, 8'h46);
  endtask

  task automatic t_hold();
    set_time(8'h20, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    @(negedge clk); hold = 1'b1;
    step_tick();
    rd_chk("R11", "frozen after first tick", 4'h0, 8'h20);
    step_tick();
    rd_chk("R11", "frozen after second tick", 4'h0, 8'h20);
    hold = 1'b0;
    @(negedge clk);
    #1 chk("R11", "catch-up one edge after release", rd_data, 8'h22);
  endtask

  task automatic t_unmapped();
    wr(4'h3, 8'h55);
    wr(4'hB, 8'h77);
    wr(4'hF, 8'h66);
    rd_chk("R9", "index 3 reads zero", 4'h3, 8'h00);
    rd_chk("R9", "index B reads zero", 4'hB, 8'h00);
    rd_chk("R9", "index F reads zero", 4'hF, 8'h00);
    rd_chk("R9", "index 5 reads zero", 4'h5, 8'h00);
    step_tick();
    rd_chk("R9", "seconds untouched by stray writes", 4'h1, 8'h00);
    rd_chk("R9", "hours untouched by stray writes", 4'h4, 8'h00);
  endtask

  task automatic t_write_path();
    set_time(8'h10, 8'h20, 8'h30, 8'h08, 8'h04, 8'h15, 8'h07, 8'h33);
    wr(4'h1, 8'h42);
    rd_chk("R12", "write readable before tick", 4'h1, 8'h42);
    step_tick();
    rd_chk("R12", "seconds loaded at tick", 4'h1, 8'h42);
    rd_chk("R12", "hundredths still stepped", 4'h0, 8'h11);
    step_tick();
    rd_chk("R12", "loaded seconds persist", 4'h1, 8'h42);
    rd_chk("R12", "hundredths keep counting", 4'h0, 8'h12);
    @(negedge clk); hold = 1'b1;
    step_tick();
    wr(4'h2, 8'h05);
    hold = 1'b0;
    rd_chk("R12", "pending write not overwritten by copy", 4'h2, 8'h05);
    rd_chk("R11", "released copy shows hundredths", 4'h0, 8'h13);
    step_tick();
    rd_chk("R12", "minutes loaded from write", 4'h2, 8'h05);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1..: run did not finish, got hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hundredths();
    t_latency();
    t_midnight();
    t_twelve_hour();
    t_month_lengths();
    t_hold();
    t_unmapped();
    t_write_path();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule